// File: doc/BRIEF.md
# Transmit Descriptor Ring Engine

This block is a bus-master transmit engine. It works through a ring of descriptors held in shared memory. Each descriptor is four 32-bit words. Software fills a descriptor and sets its ownership bit, which hands the descriptor to the engine. Software then nudges the engine by writing to a poll register. The engine fetches the descriptor and reads the buffer it points to. It presents the frame bytes on a byte stream with ready/valid flow control. Last, it writes a completion status over the descriptor's first word, and that status has the ownership bit cleared.

A descriptor can be marked as a setup frame. Its 192-byte buffer does not go to the byte stream. The engine stores it in an internal address-filter table, which the surrounding receive logic reads through a word lookup port. When the engine finds a descriptor it does not own, it parks and keeps its place. A run bit starts the engine and stops it. A stop is only honoured between descriptors.

Top module: `txr_engine`

## Requirements
- R1: The engine reads the words of a descriptor at word address P as follows: status at P, control at P+1 and buffer byte address at P+2. It works on the descriptor only when status bit 31 is 1.
- R2: If the fetched status has bit 31 equal to 0, the engine suspends without moving its pointer. A write to register address 1 (poll) then makes it fetch the same descriptor again. A poll while it is suspended and the descriptor is still not owned causes no output and no write-back.
- R3: The engine sends control bits 10:0 bytes of the buffer, starting at word (buffer address >> 2). Bytes leave each word least significant first. A length that is not a multiple of 4 stops partway through a word.
- R4: If control bit 30 (last segment) is set, tx_last is 1 on the final byte of the descriptor and on no other byte. If control bit 30 is clear, tx_last is never 1 for that descriptor.
- R5: After a normal frame has been sent, the engine writes 0x00000000 to the status word at P. Every write-back leaves bit 31 equal to 0.
- R6: A normal descriptor with length 0 sends no bytes. Its status is written back as 0x00008000, which is the error-summary bit 15.
- R7: After a descriptor whose control bit 25 (end of ring) is set, the next fetch is at the ring base. Otherwise the next fetch is at P+4.
- R8: A descriptor with control bit 27 (setup) and length 192 stores its 48 buffer words into filter entries 0 to 47 in order. It sends no bytes on the stream and writes back 0x7FFFFFFF.
- R9: A setup descriptor with any other length leaves the filter table unchanged. It sends no bytes and writes back 0x00008000.
- R10: The engine is stopped after reset. Setting bit 0 of register address 2 starts a fetch at the current pointer. Clearing that bit lets the descriptor in progress finish, including its write-back. After that, the engine makes no memory requests, and polls have no effect.
- R11: A write to register address 0 sets the ring base. While the engine is stopped or suspended, that write also moves the fetch pointer to the new base.
- R12: A memory request holds its address, direction and data until mem_ack. A byte offered while tx_ready is low holds its data and last flag until it is accepted.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| reg_wr | input | 1 | Register write strobe |
| reg_addr | input | 2 | Register select: 0 ring base, 1 poll, 2 run |
| reg_wdata | input | AW | Register write data (word address or run bit 0) |
| mem_req | output | 1 | Memory request |
| mem_we | output | 1 | Memory request is a write |
| mem_addr | output | AW | Memory word address |
| mem_wdata | output | 32 | Memory write data |
| mem_ack | input | 1 | Memory request completes this cycle |
| mem_rdata | input | 32 | Memory read data, valid with mem_ack |
| tx_valid | output | 1 | Byte on tx_data is valid |
| tx_ready | input | 1 | Downstream accepts the byte |
| tx_data | output | 8 | Frame byte |
| tx_last | output | 1 | Final byte of a last-segment descriptor |
| filt_idx | input | 6 | Filter table lookup index |
| filt_word | output | 32 | Filter table word at filt_idx |

## Verification
A table of six frames drives the main path. The lengths are 1, 4, 7, 13, 8 and 2, and tx_ready toggles irregularly throughout. These lengths separate a byte count that ends inside a word from one that ends on a word edge. One frame has last-segment clear and one has end-of-ring set, so the tx_last marking and the wrap back to the base are checked apart from the plain pointer step. Directed cases then cover the following: a zero-length frame, a poll against an unowned descriptor, a valid setup frame and one of the wrong length, a stop issued while a frame is in flight, and a base move while the engine is suspended. Each case is told apart by its write-back value, its filter contents and the address of the next status fetch.

// File: rtl/txr_pkg.sv
package txr_pkg;
  // Descriptor bit positions; software and engine both decode these.
  localparam int OWN_POS   = 31;
  localparam int LAST_POS  = 30;
  localparam int FIRST_POS = 29;
  localparam int SETUP_POS = 27;
  localparam int EOR_POS   = 25;
  localparam int ERR_POS   = 15;

  localparam int SETUP_LEN   = 192;
  localparam int SETUP_WORDS = SETUP_LEN / 4;
  localparam int FILT_IW     = $clog2(SETUP_WORDS);

  localparam logic [31:0] WB_DONE       = 32'h0000_0000;
  localparam logic [31:0] WB_SETUP_DONE = 32'h7FFF_FFFF;
  localparam logic [31:0] WB_FAULT      = 32'(1) << ERR_POS;

  localparam logic [1:0] RA_BASE = 2'd0;
  localparam logic [1:0] RA_POLL = 2'd1;
  localparam logic [1:0] RA_RUN  = 2'd2;

  typedef enum logic [2:0] {
    S_STOP, S_SUSP, S_STAT, S_CTRL, S_BUF, S_DATA, S_SEND, S_WB
  } seq_t;
endpackage

// File: rtl/txr_regs.sv
module txr_regs
  import txr_pkg::*;
#(
  parameter int AW = 16
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          reg_wr,
  input  logic [1:0]    reg_addr,
  input  logic [AW-1:0] reg_wdata,
  output logic [AW-1:0] base_q,
  output logic          run_q,
  output logic          poll_q,
  output logic          base_ld_q
);
  logic [AW-1:0] base_d;
  logic          run_d, poll_d, base_ld_d;

  always_comb begin
    base_d    = base_q;
    run_d     = run_q;
    poll_d    = 1'b0;
    base_ld_d = 1'b0;
    if (reg_wr) begin
      unique case (reg_addr)
        RA_BASE: begin
          base_d    = reg_wdata;
          base_ld_d = 1'b1;
        end
        RA_POLL: poll_d = 1'b1;
        RA_RUN:  run_d  = reg_wdata[0];
        default: ;
      endcase
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      base_q    <= '0;
      run_q     <= 1'b0;
      poll_q    <= 1'b0;
      base_ld_q <= 1'b0;
    end else begin
      base_q    <= base_d;
      run_q     <= run_d;
      poll_q    <= poll_d;
      base_ld_q <= base_ld_d;
    end
  end
endmodule

// File: rtl/txr_serializer.sv
module txr_serializer (
  input  logic        clk,
  input  logic        rst_n,
  input  logic        ld,
  input  logic [31:0] ld_word,
  input  logic [2:0]  ld_cnt,
  input  logic        ld_last,
  input  logic        tx_ready,
  output logic        tx_valid,
  output logic [7:0]  tx_data,
  output logic        tx_last,
  output logic        busy
);
  logic [31:0] word_q, word_d;
  logic [2:0]  cnt_q, cnt_d;
  logic        last_q, last_d;
  logic        shift_en;

  assign tx_valid = (cnt_q != 3'd0);
  assign busy     = tx_valid;
  assign tx_data  = word_q[7:0];
  assign tx_last  = last_q && (cnt_q == 3'd1);
  assign shift_en = tx_valid && tx_ready;

  always_comb begin
    word_d = word_q;
    cnt_d  = cnt_q;
    last_d = last_q;
    if (ld) begin
      word_d = ld_word;
      cnt_d  = ld_cnt;
      last_d = ld_last;
    end else if (shift_en) begin
      word_d = word_q >> 8;
      cnt_d  = cnt_q - 3'd1;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      word_q <= '0;
      cnt_q  <= '0;
      last_q <= 1'b0;
    end else begin
      word_q <= word_d;
      cnt_q  <= cnt_d;
      last_q <= last_d;
    end
  end

  // R12: an offered byte is held until taken
  a_r12_tx_hold: assert property (@(posedge clk) disable iff (!rst_n)
    tx_valid && !tx_ready |=> tx_valid && $stable(tx_data) && $stable(tx_last));
endmodule

// File: rtl/txr_filter.sv
module txr_filter #(
  parameter int WORDS = 48,
  parameter int IW    = $clog2(WORDS)
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          we,
  input  logic [IW-1:0] widx,
  input  logic [31:0]   wdata,
  input  logic [IW-1:0] ridx,
  output logic [31:0]   rdata
);
  logic [31:0] tbl [WORDS];

  always_ff @(posedge clk) begin
    if (we) tbl[widx] <= wdata;
  end

  assign rdata = (ridx < IW'(WORDS)) ? tbl[ridx] : '0;

  // R8: fills stay inside the table
  a_r8_fill_range: assert property (@(posedge clk) disable iff (!rst_n)
    we |-> (widx < IW'(WORDS)));
endmodule

// File: rtl/txr_seq.sv
module txr_seq
  import txr_pkg::*;
#(
  parameter int AW   = 16,
  parameter int LENW = 11
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic [AW-1:0]      base_q,
  input  logic               run_q,
  input  logic               poll_q,
  input  logic               base_ld_q,
  output logic               mem_req,
  output logic               mem_we,
  output logic [AW-1:0]      mem_addr,
  output logic [31:0]        mem_wdata,
  input  logic               mem_ack,
  input  logic [31:0]        mem_rdata,
  output logic               ser_ld,
  output logic [31:0]        ser_word,
  output logic [2:0]         ser_cnt,
  output logic               ser_last,
  input  logic               ser_busy,
  output logic               filt_we,
  output logic [FILT_IW-1:0] filt_idx,
  output logic [31:0]        filt_wdata
);
  localparam logic [LENW-1:0] LEN_SETUP = LENW'(SETUP_LEN);
  localparam logic [LENW-1:0] LEN_WORD  = LENW'(4);

  seq_t               st_q, st_d;
  logic [AW-1:0]      ptr_q, ptr_d;
  logic [AW-1:0]      wadr_q, wadr_d;
  logic [LENW-1:0]    len_q, len_d;
  logic [LENW-1:0]    rem_q, rem_d;
  logic               eor_q, eor_d, last_q, last_d, setup_q, setup_d;
  logic [FILT_IW-1:0] fidx_q, fidx_d;
  logic [31:0]        wb_q, wb_d;
  logic [2:0]         take;

  assign take       = (rem_q > LEN_WORD) ? 3'd4 : rem_q[2:0];
  assign ser_word   = mem_rdata;
  assign ser_cnt    = take;
  assign filt_idx   = fidx_q;
  assign filt_wdata = mem_rdata;

  always_comb begin
    st_d    = st_q;
    ptr_d   = ptr_q;
    wadr_d  = wadr_q;
    len_d   = len_q;
    rem_d   = rem_q;
    eor_d   = eor_q;
    last_d  = last_q;
    setup_d = setup_q;
    fidx_d  = fidx_q;
    wb_d    = wb_q;
    mem_req   = 1'b0;
    mem_we    = 1'b0;
    mem_addr  = ptr_q;
    mem_wdata = wb_q;
    ser_ld    = 1'b0;
    ser_last  = 1'b0;
    filt_we   = 1'b0;
    unique case (st_q)
      S_STOP: begin
        if (base_ld_q) ptr_d = base_q;
        if (run_q) st_d = S_STAT;
      end
      S_SUSP: begin
        if (base_ld_q) ptr_d = base_q;
        if (!run_q) st_d = S_STOP;
        else if (poll_q) st_d = S_STAT;
      end
      S_STAT: begin
        mem_req = 1'b1;
        if (mem_ack) st_d = mem_rdata[OWN_POS] ? S_CTRL : S_SUSP;
      end
      S_CTRL: begin
        mem_req  = 1'b1;
        mem_addr = ptr_q + AW'(1);
        if (mem_ack) begin
          len_d   = mem_rdata[LENW-1:0];
          eor_d   = mem_rdata[EOR_POS];
          last_d  = mem_rdata[LAST_POS];
          setup_d = mem_rdata[SETUP_POS];
          st_d    = S_BUF;
        end
      end
      S_BUF: begin
        mem_req  = 1'b1;
        mem_addr = ptr_q + AW'(2);
        if (mem_ack) begin
          wadr_d = mem_rdata[AW+1:2];
          rem_d  = len_q;
          fidx_d = '0;
          if (setup_q) begin
            if (len_q == LEN_SETUP) begin
              wb_d = WB_SETUP_DONE;
              st_d = S_DATA;
            end else begin
              wb_d = WB_FAULT;
              st_d = S_WB;
            end
          end else if (len_q == '0) begin
            wb_d = WB_FAULT;
            st_d = S_WB;
          end else begin
            wb_d = WB_DONE;
            st_d = S_DATA;
          end
        end
      end
      S_DATA: begin
        mem_req  = 1'b1;
        mem_addr = wadr_q;
        if (mem_ack) begin
          wadr_d = wadr_q + AW'(1);
          if (setup_q) begin
            filt_we = 1'b1;
            fidx_d  = fidx_q + FILT_IW'(1);
            rem_d   = rem_q - LEN_WORD;
            if (rem_q == LEN_WORD) st_d = S_WB;
          end else begin
            ser_ld   = 1'b1;
            ser_last = last_q && (rem_q <= LEN_WORD);
            rem_d    = rem_q - LENW'(take);
            st_d     = S_SEND;
          end
        end
      end
      S_SEND: begin
        if (!ser_busy) st_d = (rem_q == '0) ? S_WB : S_DATA;
      end
      S_WB: begin
        mem_req = 1'b1;
        mem_we  = 1'b1;
        if (mem_ack) begin
          ptr_d = eor_q ? base_q : ptr_q + AW'(4);
          st_d  = run_q ? S_STAT : S_STOP;
        end
      end
      default: st_d = S_STOP;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st_q    <= S_STOP;
      ptr_q   <= '0;
      wadr_q  <= '0;
      len_q   <= '0;
      rem_q   <= '0;
      eor_q   <= 1'b0;
      last_q  <= 1'b0;
      setup_q <= 1'b0;
      fidx_q  <= '0;
      wb_q    <= '0;
    end else begin
      st_q    <= st_d;
      ptr_q   <= ptr_d;
      wadr_q  <= wadr_d;
      len_q   <= len_d;
      rem_q   <= rem_d;
      eor_q   <= eor_d;
      last_q  <= last_d;
      setup_q <= setup_d;
      fidx_q  <= fidx_d;
      wb_q    <= wb_d;
    end
  end

  // R12: request fields hold until acknowledged
  a_r12_mem_hold: assert property (@(posedge clk) disable iff (!rst_n)
    mem_req && !mem_ack |=> mem_req && $stable(mem_addr) && $stable(mem_we)
                            && $stable(mem_wdata));

  // R5: a write-back always returns the descriptor to software
  a_r5_wb_released: assert property (@(posedge clk) disable iff (!rst_n)
    mem_req && mem_we |-> !mem_wdata[OWN_POS]);

  // R2: an unowned status fetch leaves the pointer where it was
  a_r2_park_in_place: assert property (@(posedge clk) disable iff (!rst_n)
    (st_q == S_STAT) && mem_ack && !mem_rdata[OWN_POS] |=> ptr_q == $past(ptr_q));
endmodule

// File: rtl/txr_engine.sv
module txr_engine
  import txr_pkg::*;
#(
  parameter int AW   = 16,
  parameter int LENW = 11
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               reg_wr,
  input  logic [1:0]         reg_addr,
  input  logic [AW-1:0]      reg_wdata,
  output logic               mem_req,
  output logic               mem_we,
  output logic [AW-1:0]      mem_addr,
  output logic [31:0]        mem_wdata,
  input  logic               mem_ack,
  input  logic [31:0]        mem_rdata,
  output logic               tx_valid,
  input  logic               tx_ready,
  output logic [7:0]         tx_data,
  output logic               tx_last,
  input  logic [FILT_IW-1:0] filt_idx,
  output logic [31:0]        filt_word
);
  logic [1:0]         rsync_q;
  logic               rst_int_n;
  logic [AW-1:0]      base_q;
  logic               run_q, poll_q, base_ld_q;
  logic               ser_ld, ser_last, ser_busy;
  logic [31:0]        ser_word;
  logic [2:0]         ser_cnt;
  logic               f_we;
  logic [FILT_IW-1:0] f_widx;
  logic [31:0]        f_wdata;

  // asynchronous assert, synchronous release
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rsync_q <= '0;
    else        rsync_q <= {rsync_q[0], 1'b1};
  end
  assign rst_int_n = rsync_q[1];

  txr_regs #(.AW(AW)) u_regs (
    .clk(clk), .rst_n(rst_int_n), .reg_wr(reg_wr), .reg_addr(reg_addr),
    .reg_wdata(reg_wdata), .base_q(base_q), .run_q(run_q), .poll_q(poll_q),
    .base_ld_q(base_ld_q)
  );

  txr_seq #(.AW(AW), .LENW(LENW)) u_seq (
    .clk(clk), .rst_n(rst_int_n), .base_q(base_q), .run_q(run_q),
    .poll_q(poll_q), .base_ld_q(base_ld_q), .mem_req(mem_req), .mem_we(mem_we),
    .mem_addr(mem_addr), .mem_wdata(mem_wdata), .mem_ack(mem_ack),
    .mem_rdata(mem_rdata), .ser_ld(ser_ld), .ser_word(ser_word),
    .ser_cnt(ser_cnt), .ser_last(ser_last), .ser_busy(ser_busy),
    .filt_we(f_we), .filt_idx(f_widx), .filt_wdata(f_wdata)
  );

  txr_serializer u_ser (
    .clk(clk), .rst_n(rst_int_n), .ld(ser_ld), .ld_word(ser_word),
    .ld_cnt(ser_cnt), .ld_last(ser_last), .tx_ready(tx_ready),
    .tx_valid(tx_valid), .tx_data(tx_data), .tx_last(tx_last), .busy(ser_busy)
  );

  txr_filter #(.WORDS(SETUP_WORDS), .IW(FILT_IW)) u_filt (
    .clk(clk), .rst_n(rst_int_n), .we(f_we), .widx(f_widx), .wdata(f_wdata),
    .ridx(filt_idx), .rdata(filt_word)
  );

  // R8: setup data never reaches the byte stream
  a_r8_setup_silent: assert property (@(posedge clk) disable iff (!rst_int_n)
    f_we |-> !tx_valid);
endmodule

// File: tb/tb_txr_engine.sv
module tb_txr_engine;
  localparam int AW = 16;
  localparam int BASE0 = 64;
  localparam logic [20:0] VEC [6] = '{
    {1'b0, 1'b1, 8'h10, 11'd1},
    {1'b0, 1'b1, 8'h20, 11'd4},
    {1'b0, 1'b0, 8'h33, 11'd7},
    {1'b1, 1'b1, 8'h47, 11'd13},
    {1'b0, 1'b1, 8'h5a, 11'd8},
    {1'b0, 1'b1, 8'h6e, 11'd2}
  };

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic reg_wr = 1'b0;
  logic [1:0] reg_addr = '0;
  logic [AW-1:0] reg_wdata = '0;
  logic mem_req, mem_we, mem_ack;
  logic [AW-1:0] mem_addr;
  logic [31:0] mem_wdata, mem_rdata;
  logic tx_valid, tx_ready, tx_last;
  logic [7:0] tx_data;
  logic [5:0] filt_idx = '0;
  logic [31:0] filt_word;

  int checks = 0, fails = 0;
  logic [31:0] mem [0:1023];
  logic [7:0] got_b [0:511];
  logic got_l [0:511];
  int got_n = 0;
  int req_cnt = 0;
  logic [AW-1:0] rd_last = '0;
  int hold_bad = 0, stall_seen = 0;
  logic [7:0] lfsr = 8'h5b;
  logic prev_stall = 1'b0;
  logic [7:0] prev_data = '0;
  logic prev_last = 1'b0;

  always #2 clk = ~clk;

  txr_engine #(.AW(AW)) dut (
    .clk(clk), .rst_n(rst_n), .reg_wr(reg_wr), .reg_addr(reg_addr),
    .reg_wdata(reg_wdata), .mem_req(mem_req), .mem_we(mem_we),
    .mem_addr(mem_addr), .mem_wdata(mem_wdata), .mem_ack(mem_ack),
    .mem_rdata(mem_rdata), .tx_valid(tx_valid), .tx_ready(tx_ready),
    .tx_data(tx_data), .tx_last(tx_last), .filt_idx(filt_idx),
    .filt_word(filt_word)
  );

  // memory model: one-cycle acknowledge
  logic ack_q = 1'b0;
  logic [31:0] rd_q = '0;
  assign mem_ack = ack_q;
  assign mem_rdata = rd_q;
  always @(posedge clk) begin
    ack_q <= mem_req && !ack_q;
    if (mem_req && !ack_q) begin
      req_cnt <= req_cnt + 1;
      rd_q <= mem[mem_addr[9:0]];
      if (mem_we) mem[mem_addr[9:0]] <= mem_wdata;
      else rd_last <= mem_addr;
    end
  end

  // stream monitor
  always @(posedge clk) begin
    if (prev_stall && (!tx_valid || tx_data != prev_data || tx_last != prev_last))
      hold_bad <= hold_bad + 1;
    prev_stall <= tx_valid && !tx_ready;
    prev_data <= tx_data;
    prev_last <= tx_last;
    if (tx_valid && !tx_ready) stall_seen <= stall_seen + 1;
    if (tx_valid && tx_ready) begin
      got_b[got_n] <= tx_data;
      got_l[got_n] <= tx_last;
      got_n <= got_n + 1;
    end
  end

  always @(negedge clk) begin
    lfsr <= {lfsr[6:0], lfsr[7] ^ lfsr[5] ^ lfsr[4] ^ lfsr[3]};
    tx_ready <= lfsr[0] | lfsr[2];
  end

  task automatic chk(string tag, logic [31:0] act, logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  task automatic reg_write(logic [1:0] a, logic [AW-1:0] d);
    @(negedge clk);
    reg_wr = 1'b1; reg_addr = a; reg_wdata = d;
    @(negedge clk);
    reg_wr = 1'b0;
  endtask

  task automatic put_desc(int p, bit own, logic [31:0] ctrl, int bufw);
    mem[p+1] = ctrl;
    mem[p+2] = 32'(bufw) << 2;
    mem[p+3] = '0;
    mem[p] = own ? 32'h8000_0000 : 32'h0;
  endtask

  task automatic fill_buf(int bufw, int len, logic [7:0] seed);
    for (int j = 0; j < len; j++)
      mem[bufw + j/4][(j%4)*8 +: 8] = seed + 8'(3*j);
  endtask

  task automatic wait_release(int p);
    for (int k = 0; k < 4000 && mem[p][31]; k++) @(negedge clk);
    repeat (12) @(negedge clk);
  endtask

  task automatic check_frame(string tag, int first, int len, logic [7:0] seed, bit ls);
    int bad = 0, lasts = 0;
    chk({tag, " R1 R3 byte count"}, 32'(got_n - first), 32'(len));
    for (int j = 0; j < len && first + j < got_n; j++) begin
      if (got_b[first+j] !== seed + 8'(3*j)) bad++;
      if (got_l[first+j]) lasts += (j == len-1) ? 1 : 100;
    end
    chk({tag, " R3 byte mismatches"}, 32'(bad), 0);
    chk({tag, " R4 last marks"}, 32'(lasts), ls ? 32'd1 : 32'd0);
  endtask

  function automatic logic [31:0] fpat(int k, logic [7:0] salt);
    return {8'(k), ~8'(k), 8'(k*7) ^ salt, 8'hC3};
  endfunction

  task automatic filt_compare(string tag, logic [7:0] salt);
    int bad = 0;
    for (int k = 0; k < 48; k++) begin
      @(negedge clk);
      filt_idx = 6'(k);
      #1;
      if (filt_word !== fpat(k, salt)) bad++;
    end
    chk(tag, 32'(bad), 0);
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    fails++;
    $display("FAIL watchdog expired");
    $display("  TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end

  initial begin
    int ptr, first, bufw;
    for (int i = 0; i < 1024; i++) mem[i] = '0;
    repeat (4) @(negedge clk);
    rst_n = 1'b1;
    repeat (4) @(negedge clk);
    chk("R10 reset no request", 32'(mem_req), 0);
    chk("R10 reset no byte", 32'(tx_valid), 0);
    chk("R10 stopped after reset", 32'(req_cnt), 0);

    reg_write(2'd0, AW'(BASE0));
    reg_write(2'd2, AW'(1));
    repeat (10) @(negedge clk);
    chk("R11 R2 first fetch at base", 32'(rd_last), BASE0);

    // table walk
    ptr = BASE0;
    for (int i = 0; i < 6; i++) begin
      logic eor, ls;
      logic [7:0] seed;
      int len;
      {eor, ls, seed} = VEC[i][20:11];
      len = int'(VEC[i][10:0]);
      bufw = 512 + 8*i;
      fill_buf(bufw, len, seed);
      first = got_n;
      put_desc(ptr, 1'b1, (32'(ls) << 30) | (32'h1 << 29) | (32'(eor) << 25) | 32'(len), bufw);
      reg_write(2'd1, '0);
      wait_release(ptr);
      check_frame($sformatf("vec%0d", i), first, len, seed, ls);
      chk($sformatf("vec%0d R5 status", i), mem[ptr], 32'h0);
      ptr = eor ? BASE0 : ptr + 4;
      chk($sformatf("vec%0d R7 next fetch", i), 32'(rd_last), 32'(ptr));
    end

    // R6 zero length
    first = got_n;
    put_desc(ptr, 1'b1, 32'h4000_0000, 560);
    reg_write(2'd1, '0);
    wait_release(ptr);
    chk("R6 zero length no bytes", 32'(got_n - first), 0);
    chk("R6 zero length status", mem[ptr], 32'h0000_8000);
    ptr = ptr + 4;

    // R2 poll against unowned descriptor
    fill_buf(570, 5, 8'h81);
    first = got_n;
    put_desc(ptr, 1'b0, 32'h4200_0005, 570);
    reg_write(2'd1, '0);
    repeat (30) @(negedge clk);
    chk("R2 unowned no bytes", 32'(got_n - first), 0);
    chk("R2 unowned refetched in place", 32'(rd_last), 32'(ptr));
    chk("R2 unowned no write-back", mem[ptr], 32'h0);
    mem[ptr] = 32'h8000_0000;
    reg_write(2'd1, '0);
    wait_release(ptr);
    check_frame("R2 after ownership", first, 5, 8'h81, 1'b1);
    ptr = BASE0;
    chk("R7 wrap after own", 32'(rd_last), 32'(ptr));

    // R8 valid setup frame
    for (int k = 0; k < 48; k++) mem[600 + k] = fpat(k, 8'h00);
    first = got_n;
    put_desc(ptr, 1'b1, (32'h1 << 27) | 32'd192, 600);
    reg_write(2'd1, '0);
    wait_release(ptr);
    chk("R8 setup no bytes", 32'(got_n - first), 0);
    chk("R8 setup status", mem[ptr], 32'h7FFF_FFFF);
    filt_compare("R8 filter contents", 8'h00);
    ptr = ptr + 4;

    // R9 wrong-length setup frame
    for (int k = 0; k < 48; k++) mem[700 + k] = fpat(k, 8'hFF);
    put_desc(ptr, 1'b1, (32'h1 << 27) | 32'd96, 700);
    reg_write(2'd1, '0);
    wait_release(ptr);
    chk("R9 bad setup no bytes", 32'(got_n - first), 0);
    chk("R9 bad setup status", mem[ptr], 32'h0000_8000);
    filt_compare("R9 filter unchanged", 8'h00);
    ptr = ptr + 4;

    // R10 stop during a frame
    fill_buf(800, 40, 8'h19);
    first = got_n;
    put_desc(ptr, 1'b1, 32'h6000_0028, 800);
    reg_write(2'd1, '0);
    for (int k = 0; k < 2000 && got_n < first + 3; k++) @(negedge clk);
    reg_write(2'd2, '0);
    wait_release(ptr);
    check_frame("R10 frame finishes after stop", first, 40, 8'h19, 1'b1);
    chk("R10 stopped frame status", mem[ptr], 32'h0);
    ptr = ptr + 4;
    begin
      int reqs;
      fill_buf(820, 3, 8'hA0);
      first = got_n;
      put_desc(ptr, 1'b1, 32'h6200_0003, 820);
      repeat (4) @(negedge clk);
      reqs = req_cnt;
      reg_write(2'd1, '0);
      repeat (40) @(negedge clk);
      chk("R10 stopped ignores poll bytes", 32'(got_n - first), 0);
      chk("R10 stopped no requests", 32'(req_cnt - reqs), 0);
      chk("R10 descriptor still owned", 32'(mem[ptr][31]), 1);
    end
    reg_write(2'd2, AW'(1));
    wait_release(ptr);
    check_frame("R10 restart", first, 3, 8'hA0, 1'b1);
    chk("R7 R10 wrap after restart", 32'(rd_last), BASE0);

    // R11 base move while suspended
    reg_write(2'd0, AW'(300));
    fill_buf(900, 6, 8'h3C);
    first = got_n;
    put_desc(300, 1'b1, 32'h6200_0006, 900);
    reg_write(2'd1, '0);
    wait_release(300);
    check_frame("R11 new base", first, 6, 8'h3C, 1'b1);
    chk("R11 status at new base", mem[300], 32'h0);
    chk("R11 R7 wrap to new base", 32'(rd_last), 300);

    chk("R12 stream held under stall", 32'(hold_bad), 0);
    chk("R12 stalls exercised", 32'(stall_seen > 0), 1);

    $display("  TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end
endmodule